// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address by reading the translation tables from memory, one 8-byte table entry at a time. A walk runs three levels for the 39-bit layout or four levels for the 48-bit layout. The `sv48` input picks the layout when the walk starts. Before any table is read, the walker checks that the upper address bits are a proper sign extension. It then descends from the root table and checks every entry it reads against the structural rules. It stops at the first leaf or at the first violation. The final permission verdict comes from a separate checker: the walker shows that checker the leaf entry for one cycle and folds its answer into the result.

The walker holds one walk at a time. While a walk runs, `busy` is high and `start` has no effect. Table entries travel over a request/response port: a request is a valid/ready address handshake, and the reply is a single-cycle valid carrying the 64-bit entry. Each walk ends with a one-cycle `done` pulse. With it come a fault flag and either the physical address and memory attribute (on success) or the offending virtual address (on a fault). Leaves above level 0 give 2 MiB, 1 GiB or 512 GiB pages. A level-0 leaf marked contiguous gives a 64 KiB page.

The controller has four states:
- IDLE waits for `start`.
- REQ drives a table read.
- WAIT holds for the reply and judges the entry.
- FINISH shows the leaf to the checker and produces the result.

The transitions are:
- IDLE→REQ when `start` arrives with a canonical address.
- IDLE→FINISH when `start` arrives with a non-canonical address.
- REQ→WAIT when the request is accepted.
- WAIT→REQ when the entry points to a lower table.
- WAIT→FINISH when the entry is a leaf or is faulty.
- FINISH→IDLE always.

Top module: `ptw_walker`

## Requirements
- R1: After reset `busy`, `done` and `mem_req_valid` are low.
- R2: A walk reads 3 entries for `sv48`=0 and 4 entries for `sv48`=1, down to a level-0 leaf. The first table base is `root_ppn`<<12. Each read address is base + VPN[i]*8, where VPN[i] = va[12+9i +: 9] and i counts down from the top level. Each lower base is the entry's PPN<<12.
- R3: The walk faults with no memory read if va[63:38] (`sv48`=0) or va[63:47] (`sv48`=1) is neither all zeros nor all ones. Sign-extended negative addresses walk normally.
- R4: Entry fields are V bit 0, R 1, W 2, X 3, U 4, A 6, D 7, PPN 53:10, reserved 60:54, memory attribute 62:61 and N 63. An entry faults if V=0, if W=1 with R=0, or if any reserved bit is set.
- R5: A nonzero attribute faults while `pbmt_on`=0. An attribute of 3 always faults. On success the leaf's attribute appears on `pbmt_out`.
- R6: An entry with R=0 and X=0 points to a lower table. Such an entry faults if A, D, U, attribute or N is nonzero, and it faults at level 0.
- R7: A leaf at level L>0 faults if PPN[9L-1:0] is nonzero or if N=1. Otherwise PA[12+9L-1:12] comes from the virtual address.
- R8: A level-0 leaf with N=1 faults unless PPN[3:0]=4'b1000. Otherwise PA[15:12] comes from va[15:12].
- R9: Whenever the walk has read at least one entry, the last entry read appears on `leaf_pte` with `leaf_pte_valid` high for exactly one cycle. If `perm_ok` is low in that cycle, a walk that would otherwise succeed faults.
- R10: `mem_req_valid` and `mem_req_addr` stay stable until `mem_req_ready`. No new request is issued until the previous reply has arrived.
- R11: `done` is a one-cycle pulse. On success `pa` = translated page plus va[11:0] and `fault_va` = 0. On a fault `fault_va` = va, and `pa` and `pbmt_out` are 0.
- R12: A `start` pulse while `busy` is high does not change the running walk or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| va | input | 64 | Virtual address to translate |
| root_ppn | input | 44 | Page number of the top-level table |
| sv48 | input | 1 | 1: four-level layout, 0: three-level layout |
| pbmt_on | input | 1 | Allows nonzero memory attributes in entries |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 56 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry reply valid |
| mem_rsp_pte | input | 64 | Returned table entry |
| leaf_pte_valid | output | 1 | Final entry presented to the permission checker |
| leaf_pte | output | 64 | Final entry read by the walk |
| perm_ok | input | 1 | Permission checker verdict for `leaf_pte` |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | The walk ended in a fault |
| pa | output | 56 | Physical address (0 on fault) |
| pbmt_out | output | 2 | Memory attribute of the leaf (0 on fault) |
| fault_va | output | 64 | Faulting virtual address (0 on success) |

## Verification
The bench builds the walker with contiguous-page support enabled (`NAPOT_ON`=1). This makes both the good and bad 64 KiB encodings reachable, and it lets the superpage-with-N fault be separated from the disabled-support fault. The bench drives `pbmt_on` both ways, so the attribute-enabled path and the attribute-disabled fault are both exercised. Table reads are answered under an irregular ready pattern, which exercises the request hold and the one-outstanding rule across 3-level and 4-level walks, superpages at levels 1 and 2, and negative canonical addresses.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int PG_SHIFT  = 12;
    localparam int VPN_W     = 9;
    localparam int PPN_W     = 44;
    localparam int PA_W      = PPN_W + PG_SHIFT;
    localparam int VA_W      = 64;
    localparam int PTE_W     = 64;
    localparam int LVL_W     = 2;
    localparam int ENTRY_LG  = 3;
    localparam int SV39_TOP  = PG_SHIFT + 3 * VPN_W - 1;
    localparam int SV48_TOP  = PG_SHIFT + 4 * VPN_W - 1;
    localparam int NAPOT_W   = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_FINISH
    } walk_state_e;

    typedef enum logic [1:0] {
        VD_FAULT,
        VD_DESCEND,
        VD_LEAF
    } verdict_e;

    typedef struct packed {
        logic             n;
        logic [1:0]       attr;
        logic [6:0]       rsv;
        logic [PPN_W-1:0] ppn;
        logic [1:0]       sw;
        logic             d;
        logic             a;
        logic             g;
        logic             u;
        logic             x;
        logic             w;
        logic             r;
        logic             v;
    } pte_t;
endpackage

// File: rtl/ptw_canon.sv
module ptw_canon
    import ptw_pkg::*;
(
    input  logic [VA_W-1:SV39_TOP] va_hi,
    input  logic                   sv48,
    output logic                   canon_ok
);
    logic ok39;
    logic ok48;

    always_comb begin
        ok39 = (&va_hi) | ~(|va_hi);
        ok48 = (&va_hi[VA_W-1:SV48_TOP]) | ~(|va_hi[VA_W-1:SV48_TOP]);
        canon_ok = sv48 ? ok48 : ok39;
    end
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
    import ptw_pkg::*;
#(
    parameter bit NAPOT_ON = 1'b1
) (
    input  pte_t             pte,
    input  logic [LVL_W-1:0] lvl,
    input  logic             pbmt_on,
    input  logic [PA_W-1:0]  va_lo,
    output verdict_e         verdict,
    output logic [PA_W-1:0]  leaf_pa
);
    logic [5:0]       sh;
    logic [PPN_W-1:0] lo_mask;
    logic [PPN_W-1:0] va_pn;
    logic [PPN_W-1:0] ppn_out;
    logic             bad_entry;
    logic             is_leaf;
    logic             ptr_dirty;
    logic             unused_bits;

    assign unused_bits = ^{pte.g, pte.sw};

    always_comb begin
        sh        = {1'b0, lvl, 3'b000} + {4'b0000, lvl};
        va_pn     = va_lo[PA_W-1:PG_SHIFT];
        bad_entry = !pte.v || (pte.w && !pte.r) || (|pte.rsv)
                  || ((pte.attr != 2'd0) && !pbmt_on) || (pte.attr == 2'd3)
                  || (pte.n && !NAPOT_ON);
        is_leaf   = pte.r | pte.x;
        ptr_dirty = pte.a | pte.d | pte.u | (|pte.attr) | pte.n;
        lo_mask   = '0;
        if (lvl != '0) begin
            lo_mask = ~({PPN_W{1'b1}} << sh);
        end else if (pte.n) begin
            lo_mask = PPN_W'((1 << NAPOT_W) - 1);
        end
        ppn_out = (pte.ppn & ~lo_mask) | (va_pn & lo_mask);
        leaf_pa = {ppn_out, va_lo[PG_SHIFT-1:0]};

        verdict = VD_LEAF;
        if (bad_entry) begin
            verdict = VD_FAULT;
        end else if (!is_leaf) begin
            verdict = (ptr_dirty || lvl == '0) ? VD_FAULT : VD_DESCEND;
        end else if (lvl != '0) begin
            if ((|(pte.ppn & lo_mask)) || pte.n) verdict = VD_FAULT;
        end else if (pte.n && pte.ppn[NAPOT_W-1:0] != 4'b1000) begin
            verdict = VD_FAULT;
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter bit NAPOT_ON = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VA_W-1:0]   va,
    input  logic [PPN_W-1:0]  root_ppn,
    input  logic              sv48,
    input  logic              pbmt_on,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_pte,
    output logic              leaf_pte_valid,
    output logic [PTE_W-1:0]  leaf_pte,
    input  logic              perm_ok,
    output logic              done,
    output logic              fault,
    output logic [PA_W-1:0]   pa,
    output logic [1:0]        pbmt_out,
    output logic [VA_W-1:0]   fault_va
);
    walk_state_e      state_q, state_d;
    logic [LVL_W-1:0] lvl_q;
    logic [VA_W-1:0]  va_q;
    logic             pbmt_on_q;
    logic [PA_W-1:0]  base_q;
    pte_t             pte_q;
    logic             had_pte_q;
    logic             sfault_q;
    logic [PA_W-1:0]  pa_q;
    logic             canon_ok;
    verdict_e         verdict;
    logic [PA_W-1:0]  leaf_pa;
    logic [VPN_W-1:0] vpn;

    ptw_canon u_canon (
        .va_hi    (va[VA_W-1:SV39_TOP]),
        .sv48     (sv48),
        .canon_ok (canon_ok)
    );

    ptw_pte_check #(.NAPOT_ON(NAPOT_ON)) u_check (
        .pte     (pte_t'(mem_rsp_pte)),
        .lvl     (lvl_q),
        .pbmt_on (pbmt_on_q),
        .va_lo   (va_q[PA_W-1:0]),
        .verdict (verdict),
        .leaf_pa (leaf_pa)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = canon_ok ? ST_REQ : ST_FINISH;
            ST_REQ:    if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT:   if (mem_rsp_valid) state_d = (verdict == VD_DESCEND) ? ST_REQ : ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q     <= '0;
            va_q      <= '0;
            pbmt_on_q <= 1'b0;
            base_q    <= '0;
            pte_q     <= '0;
            had_pte_q <= 1'b0;
            sfault_q  <= 1'b0;
            pa_q      <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    va_q      <= va;
                    pbmt_on_q <= pbmt_on;
                    lvl_q     <= sv48 ? LVL_W'(3) : LVL_W'(2);
                    base_q    <= {root_ppn, {PG_SHIFT{1'b0}}};
                    had_pte_q <= 1'b0;
                    sfault_q  <= !canon_ok;
                end
                ST_WAIT: if (mem_rsp_valid) begin
                    pte_q     <= pte_t'(mem_rsp_pte);
                    had_pte_q <= 1'b1;
                    unique case (verdict)
                        VD_FAULT:   sfault_q <= 1'b1;
                        VD_DESCEND: begin
                            base_q <= {mem_rsp_pte[PG_SHIFT-2 +: PPN_W], {PG_SHIFT{1'b0}}};
                            lvl_q  <= lvl_q - 1'b1;
                        end
                        default: begin
                            sfault_q <= 1'b0;
                            pa_q     <= leaf_pa;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        vpn            = va_q[PG_SHIFT + VPN_W * int'(lvl_q) +: VPN_W];
        busy           = (state_q != ST_IDLE);
        mem_req_valid  = (state_q == ST_REQ);
        mem_req_addr   = base_q + {{(PA_W-VPN_W-ENTRY_LG){1'b0}}, vpn, {ENTRY_LG{1'b0}}};
        leaf_pte_valid = (state_q == ST_FINISH) && had_pte_q;
        leaf_pte       = pte_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            fault    <= 1'b0;
            pa       <= '0;
            pbmt_out <= '0;
            fault_va <= '0;
        end else if (state_q == ST_FINISH) begin
            done <= 1'b1;
            if (sfault_q || (had_pte_q && !perm_ok)) begin
                fault    <= 1'b1;
                pa       <= '0;
                pbmt_out <= '0;
                fault_va <= va_q;
            end else begin
                fault    <= 1'b0;
                pa       <= pa_q;
                pbmt_out <= pte_q.attr;
                fault_va <= '0;
            end
        end else begin
            done <= 1'b0;
        end
    end

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    assert_no_read_noncanon_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !canon_ok |=> !mem_req_valid);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_leaf_then_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        leaf_pte_valid |=> done);

    assert_floor_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_WAIT && mem_rsp_valid && lvl_q == '0 |=> state_q != ST_REQ);
endmodule

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;
    localparam logic [43:0] ROOT = 44'h80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] va = '0;
    logic [43:0] root_ppn = ROOT;
    logic        sv48 = 1'b0;
    logic        pbmt_on = 1'b0;
    logic        busy;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [55:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_pte = '0;
    logic        leaf_pte_valid;
    logic [63:0] leaf_pte;
    logic        perm_ok = 1'b1;
    logic        done;
    logic        fault;
    logic [55:0] pa;
    logic [1:0]  pbmt_out;
    logic [63:0] fault_va;

    always #5 clk = ~clk;

    ptw_walker #(.NAPOT_ON(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .va(va), .root_ppn(root_ppn),
        .sv48(sv48), .pbmt_on(pbmt_on), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_pte(mem_rsp_pte), .leaf_pte_valid(leaf_pte_valid),
        .leaf_pte(leaf_pte), .perm_ok(perm_ok), .done(done), .fault(fault),
        .pa(pa), .pbmt_out(pbmt_out), .fault_va(fault_va)
    );

    int n_vec = 0;
    int n_bad = 0;
    logic [63:0] mem [logic [55:0]];
    logic [55:0] exp_q[$];
    int          rd_cnt;
    int          leaf_cycles;
    logic [63:0] leaf_seen;
    logic [63:0] last_rd;

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // memory model and monitor
    initial begin
        bit          pend = 0;
        logic [55:0] a = '0;
        int          tick = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_pte   = mem.exists(a) ? mem[a] : 64'd0;
                last_rd       = mem_rsp_pte;
                pend          = 0;
            end
            if (leaf_pte_valid) begin
                leaf_cycles++;
                leaf_seen = leaf_pte;
            end
            mem_req_ready = (tick % 3) != 2;
            tick++;
            if (rst_n && mem_req_valid && mem_req_ready) begin
                pend = 1;
                a    = mem_req_addr;
                rd_cnt++;
                if (exp_q.size() > 0) chk("R2 read address", 64'(a), 64'(exp_q.pop_front()));
                else                  chk("R2 unexpected read", 64'(a), 64'hFFFF_FFFF_FFFF_FFFF);
            end
        end
    end

    function automatic logic [63:0] mk(input logic [43:0] ppn, input logic [7:0] fl,
                                       input logic [1:0] at, input logic n, input logic [6:0] rsv);
        return {n, at, rsv, ppn, 2'b00, fl};
    endfunction

    function automatic logic [55:0] vpn8(input logic [63:0] v, input int l);
        return 56'(((v >> (12 + 9 * l)) & 64'h1FF) * 8);
    endfunction

    // install a table path ending at leaf_lvl with entry leaf
    task automatic build(input logic [63:0] v, input bit s48, input int leaf_lvl, input logic [63:0] leaf);
        logic [55:0] base = {ROOT, 12'h0};
        int top = s48 ? 3 : 2;
        mem.delete();
        for (int l = top; l > leaf_lvl; l--) begin
            logic [43:0] nxt = ROOT + 44'(16 * (top - l + 1));
            mem[base + vpn8(v, l)] = mk(nxt, 8'h01, 2'd0, 1'b0, 7'd0);
            base = {nxt, 12'h0};
        end
        mem[base + vpn8(v, leaf_lvl)] = leaf;
    endtask

    // behavioural reference walk
    task automatic model(input logic [63:0] v, input bit s48, input bit pon, input bit perm,
                         output bit f, output logic [55:0] epa, output logic [1:0] eat,
                         output int nrd, output logic [63:0] elast);
        longint hi = longint'(v) >>> (s48 ? 47 : 38);
        logic [55:0] base = {ROOT, 12'h0};
        bit stop = 0;
        f = 0; epa = '0; eat = '0; nrd = 0; elast = '0;
        exp_q.delete();
        if (hi != 0 && hi != -1) begin
            f = 1;
            return;
        end
        for (int l = (s48 ? 3 : 2); l >= 0 && !stop; l--) begin
            logic [55:0] ad = base + vpn8(v, l);
            logic [63:0] p = mem.exists(ad) ? mem[ad] : 64'd0;
            logic [43:0] ppn = p[53:10];
            logic [43:0] msk;
            exp_q.push_back(ad);
            nrd++;
            elast = p;
            stop = 1;
            if (!p[0] || (p[2] && !p[1]) || p[60:54] != 0 || (p[62:61] != 0 && !pon) || p[62:61] == 3) begin
                f = 1;
            end else if (!p[1] && !p[3]) begin
                if (p[4] || p[6] || p[7] || p[62:61] != 0 || p[63] || l == 0) f = 1;
                else begin
                    base = {ppn, 12'h0};
                    stop = 0;
                end
            end else begin
                msk = (l > 0) ? 44'((64'd1 << (9 * l)) - 1) : (p[63] ? 44'hF : 44'h0);
                if (l > 0 && ((ppn & msk) != 0 || p[63])) f = 1;
                else if (l == 0 && p[63] && ppn[3:0] != 4'b1000) f = 1;
                else begin
                    f   = !perm;
                    epa = {(ppn & ~msk) | (v[55:12] & msk), v[11:0]};
                    eat = p[62:61];
                end
            end
        end
        if (f) begin
            epa = '0;
            eat = '0;
        end
    endtask

    task automatic run(input string rq, input logic [63:0] v, input bit s48, input bit pon,
                       input bit perm, input bit poke);
        bit f;
        logic [55:0] epa;
        logic [1:0] eat;
        int nrd;
        logic [63:0] elast;
        int cyc = 0;
        model(v, s48, pon, perm, f, epa, eat, nrd, elast);
        rd_cnt = 0;
        leaf_cycles = 0;
        @(negedge clk);
        va = v; sv48 = s48; pbmt_on = pon; perm_ok = perm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 400) begin
            if (poke && cyc == 3) begin
                va = v ^ 64'h0010_0000; sv48 = !s48; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        if (!done) begin
            chk({rq, " walk timeout"}, 64'(done), 64'd1);
        end else begin
            chk({rq, " fault"}, 64'(fault), 64'(f));
            chk({rq, " pa (R11)"}, 64'(pa), 64'(epa));
            chk({rq, " pbmt_out (R5)"}, 64'(pbmt_out), 64'(eat));
            chk({rq, " fault_va (R11)"}, fault_va, f ? v : 64'd0);
            chk({rq, " read count (R2)"}, 64'(rd_cnt), 64'(nrd));
            chk({rq, " leaf cycles (R9)"}, 64'(leaf_cycles), (nrd > 0) ? 64'd1 : 64'd0);
            if (nrd > 0) chk({rq, " leaf entry (R9)"}, leaf_seen, elast);
            @(negedge clk);
            chk({rq, " done single cycle (R11)"}, 64'(done), 64'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] v39 = 64'h0000_0012_3456_7ABC;
        logic [63:0] vneg = 64'hFFFF_FFC0_1234_5678;
        logic [63:0] v48 = 64'h0000_7ABC_1234_5678;
        repeat (3) @(negedge clk);
        chk("R1 busy after reset", 64'(busy), 64'd0);
        chk("R1 done after reset", 64'(done), 64'd0);
        chk("R1 request after reset", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;

        build(v39, 0, 0, mk(44'h12345, 8'hCF, 2'd0, 1'b0, 7'd0));
        run("R2 sv39 4K", v39, 0, 0, 1, 0);
        build(v48, 1, 0, mk(44'h12345, 8'hCF, 2'd0, 1'b0, 7'd0));
        run("R2 sv48 4K", v48, 1, 0, 1, 0);
        build(vneg, 0, 0, mk(44'h23456, 8'hCB, 2'd0, 1'b0, 7'd0));
        run("R3 negative canonical", vneg, 0, 0, 1, 0);
        run("R3 sv39 noncanonical", 64'h0000_0080_0000_0000, 0, 0, 1, 0);
        run("R3 sv48 noncanonical", 64'h0000_8000_0000_0000, 1, 0, 1, 0);

        build(v39, 0, 0, mk(44'h12345, 8'hCE, 2'd0, 1'b0, 7'd0));
        run("R4 V clear", v39, 0, 0, 1, 0);
        build(v39, 0, 0, mk(44'h12345, 8'hC5, 2'd0, 1'b0, 7'd0));
        run("R4 W without R", v39, 0, 0, 1, 0);
        build(v39, 0, 0, mk(44'h12345, 8'hCF, 2'd0, 1'b0, 7'h10));
        run("R4 reserved bit", v39, 0, 0, 1, 0);

        build(v39, 0, 0, mk(44'h12345, 8'hCF, 2'd1, 1'b0, 7'd0));
        run("R5 attr while disabled", v39, 0, 0, 1, 0);
        run("R5 attr enabled", v39, 0, 1, 1, 0);
        build(v39, 0, 0, mk(44'h12345, 8'hCF, 2'd3, 1'b0, 7'd0));
        run("R5 attr value 3", v39, 0, 1, 1, 0);

        build(v39, 0, 1, mk(44'h300, 8'h41, 2'd0, 1'b0, 7'd0));
        run("R6 pointer with A", v39, 0, 0, 1, 0);
        build(v39, 0, 0, mk(44'h300, 8'h01, 2'd0, 1'b0, 7'd0));
        run("R6 pointer at level 0", v39, 0, 0, 1, 0);

        build(v39, 0, 1, mk(44'h12200, 8'hCF, 2'd0, 1'b0, 7'd0));
        run("R7 2M aligned", v39, 0, 0, 1, 0);
        build(v39, 0, 1, mk(44'h12201, 8'hCF, 2'd0, 1'b0, 7'd0));
        run("R7 2M misaligned", v39, 0, 0, 1, 0);
        build(v39, 0, 2, mk(44'h40000, 8'hCF, 2'd0, 1'b0, 7'd0));
        run("R7 1G aligned", v39, 0, 0, 1, 0);
        build(v39, 0, 1, mk(44'h12200, 8'hCF, 2'd0, 1'b1, 7'd0));
        run("R7 superpage with N", v39, 0, 0, 1, 0);

        build(v39, 0, 0, mk(44'h12348, 8'hCF, 2'd0, 1'b1, 7'd0));
        run("R8 64K good", v39, 0, 0, 1, 0);
        build(v39, 0, 0, mk(44'h12341, 8'hCF, 2'd0, 1'b1, 7'd0));
        run("R8 64K bad pattern", v39, 0, 0, 1, 0);

        build(v48, 1, 0, mk(44'h12345, 8'hCF, 2'd0, 1'b0, 7'd0));
        run("R9 permission denied", v48, 1, 0, 0, 0);
        run("R10 R12 start while busy", v48, 1, 0, 1, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule